// File: doc/BRIEF.md
# Synchronous Memory-Card Activation Sequencer

This block powers up a synchronous-protocol memory card and then moves single bits between the host and the card. The host asks for card supply with a one-cycle request that carries a timer value. It then picks one of two conditions to start activation. The first is the supply-good input. The second is the expiry of a supply timer that loads on that request. A short settling phase follows, with IO left undriven. The sequencer then enters its active state. From that point the host gates the card clock, sets the card reset line and picks the transfer direction.

Once active, the card clock runs with a programmable half-bit period in system-clock cycles. While the clock-off control is set, the card clock rests at a selectable level. When the clock is enabled from a low rest level, the first rising edge comes no earlier than half a bit period later. In transmit, data leaves LSB first and changes on the falling card-clock edge. In receive, IO is sampled on the rising edge and shifted in LSB first. A bit counter counts rising edges up to a reloadable limit. When it reaches the limit it raises a sticky interrupt. Flipping the direction control clears the count.

Top module: `sc_sync_seq`

## Requirements
- R1: With `rdy_gate`=1 the sequencer leaves the waiting state only on `sup_good`=1, even if the timer has expired. With `rdy_gate`=0 it leaves on timer expiry.
- R2: A `pwr_req` pulse loads the supply timer with `pwr_tmo`. `sup_expired` goes high `pwr_tmo` cycles after the loading edge and stays high.
- R3: `act_done` rises exactly 4 clocks after the edge on which the start condition was seen. Before that, and whenever receive mode is selected, `io_oe`=0 and `io_out`=1.
- R4: `card_rst` equals `rst_bit` of the previous clock, without inversion.
- R5: While active with `clk_off`=0, `card_clk` alternates `half_bit` cycles low and `half_bit` cycles high, starting from its rest level. With `clk_off`=1 it is held at `clk_idle`, and it is held at 0 when not active. After `clk_off` is cleared with a low rest level, the first rise comes `half_bit` cycles later.
- R6: The bit counter advances on each rising card-clock edge. It sets `irq` on the edge where it reaches the reload limit. `irq` then stays high until an `irq_clr` pulse.
- R7: A change of `dir_tx` clears the bit counter. A `len_reload` pulse clears it and latches `len_val` as the new limit and `tx_data` as the transmit word.
- R8: In transmit (`dir_tx`=1, encoded 1 = transmit), `io_oe`=1 and `io_out` carries `tx_data` bit 0 first. `io_out` moves to the next bit only on a falling card-clock edge.
- R9: In receive (`dir_tx`=0), `io_in` is sampled on each rising card-clock edge and shifted into `rx_data` from the MSB end. After DW bits, the first bit received sits in bit 0.
- R10: A synchronous low `rst_n` returns to idle with `card_clk`=0, `io_oe`=0, `card_rst`=0, `irq`=0 and `act_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_req | input | 1 | Supply-select request pulse; loads the timer |
| pwr_tmo | input | TMR_W | Supply timer load value in cycles |
| rdy_gate | input | 1 | 1: start on supply-good; 0: start on timer expiry |
| sup_good | input | 1 | Supply-good indication |
| clk_off | input | 1 | Holds the card clock at its rest level |
| clk_idle | input | 1 | Rest level of the card clock |
| rst_bit | input | 1 | Host card-reset control |
| dir_tx | input | 1 | Direction: 1 transmit, 0 receive |
| half_bit | input | HP_W | Half bit period in cycles (at least 1) |
| len_val | input | CNT_W | Bit-length limit for reload |
| len_reload | input | 1 | Reload pulse for limit and transmit word |
| tx_data | input | DW | Transmit word |
| irq_clr | input | 1 | Interrupt clear pulse |
| io_in | input | 1 | IO line as seen from the card |
| card_clk | output | 1 | Card clock |
| card_rst | output | 1 | Card reset |
| io_out | output | 1 | IO drive value |
| io_oe | output | 1 | IO drive enable |
| rx_data | output | DW | Received bits |
| irq | output | 1 | Bit-length interrupt |
| act_done | output | 1 | Activation complete |
| sup_expired | output | 1 | Supply timer expired |

## Verification
The bench builds the block with DW=8, CNT_W=5, TMR_W=8, HP_W=4 and SETTLE_CYC=4, and runs it with a half-bit period of 3. The short timer width and a timeout of 6 let the expiry path, settling and clock start all happen within a few dozen cycles. A half period of 3 leaves room between card-clock edges for the bench to drive `io_in` and to toggle the direction while the clock is stopped. An 8-bit word is short enough to check whole transmit and receive words, a short limit of 3 alongside the full limit of 8.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WAIT   = 2'd1,
      ST_SETTLE = 2'd2,
      ST_ACTIVE = 2'd3
   } seq_state_t;
endpackage

// File: rtl/sc_supply_timer.sv
module sc_supply_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TMR_W-1:0] load_val,
   output logic             expired
);
   logic [TMR_W-1:0] cnt_q;
   logic             arm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         arm_q <= 1'b0;
      end else if (load) begin
         cnt_q <= load_val;
         arm_q <= 1'b1;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = arm_q && (cnt_q == '0);
endmodule

// File: rtl/sc_card_clock.sv
module sc_card_clock #(
   parameter int HP_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            hold_lvl,
   input  logic [HP_W-1:0] half_bit,
   output logic            card_clk,
   output logic            rise_evt,
   output logic            fall_evt
);
   logic [HP_W-1:0] ph_q;
   logic            lvl_q;
   logic            ph_end;

   assign ph_end   = run && (ph_q == half_bit - 1'b1);
   assign rise_evt = ph_end && !lvl_q;
   assign fall_evt = ph_end && lvl_q;
   assign card_clk = lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= '0;
         lvl_q <= 1'b0;
      end else if (!run) begin
         ph_q  <= '0;
         lvl_q <= hold_lvl;
      end else if (ph_end) begin
         ph_q  <= '0;
         lvl_q <= !lvl_q;
      end else begin
         ph_q  <= ph_q + 1'b1;
      end
   end
endmodule

// File: rtl/sc_bit_engine.sv
module sc_bit_engine #(
   parameter int DW    = 8,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dir_tx,
   input  logic             len_reload,
   input  logic [CNT_W-1:0] len_val,
   input  logic [DW-1:0]    tx_data,
   input  logic             irq_clr,
   input  logic             rise_evt,
   input  logic             fall_evt,
   input  logic             io_in,
   output logic             dir_q,
   output logic             tx_bit,
   output logic [DW-1:0]    rx_data,
   output logic             irq
);
   logic [CNT_W-1:0] cnt_q, lim_q, cnt_nx;
   logic [DW-1:0]    tx_q, rx_q;
   logic             irq_q, flip, step, hit;

   assign flip   = dir_tx != dir_q;
   assign cnt_nx = cnt_q + 1'b1;
   assign step   = rise_evt && !len_reload && !flip && (cnt_q != lim_q);
   assign hit    = step && (cnt_nx == lim_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= 1'b0;
         cnt_q <= '0;
         lim_q <= '0;
         tx_q  <= '0;
         rx_q  <= '0;
         irq_q <= 1'b0;
      end else begin
         dir_q <= dir_tx;
         if (len_reload) begin
            cnt_q <= '0;
            lim_q <= len_val;
            tx_q  <= tx_data;
         end else begin
            if (flip)
               cnt_q <= '0;
            else if (step)
               cnt_q <= cnt_nx;
            if (fall_evt && dir_q)
               tx_q <= {1'b1, tx_q[DW-1:1]};
         end
         if (rise_evt && !dir_q)
            rx_q <= {io_in, rx_q[DW-1:1]};
         if (hit)
            irq_q <= 1'b1;
         else if (irq_clr)
            irq_q <= 1'b0;
      end
   end

   assign tx_bit  = tx_q[0];
   assign rx_data = rx_q;
   assign irq     = irq_q;
endmodule

// File: rtl/sc_sync_seq.sv
module sc_sync_seq
   import sc_seq_pkg::*;
#(
   parameter int DW         = 8,
   parameter int CNT_W      = 6,
   parameter int TMR_W      = 16,
   parameter int HP_W       = 8,
   parameter int SETTLE_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_req,
   input  logic [TMR_W-1:0] pwr_tmo,
   input  logic             rdy_gate,
   input  logic             sup_good,
   input  logic             clk_off,
   input  logic             clk_idle,
   input  logic             rst_bit,
   input  logic             dir_tx,
   input  logic [HP_W-1:0]  half_bit,
   input  logic [CNT_W-1:0] len_val,
   input  logic             len_reload,
   input  logic [DW-1:0]    tx_data,
   input  logic             irq_clr,
   input  logic             io_in,
   output logic             card_clk,
   output logic             card_rst,
   output logic             io_out,
   output logic             io_oe,
   output logic [DW-1:0]    rx_data,
   output logic             irq,
   output logic             act_done,
   output logic             sup_expired
);
   localparam int SC_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

   generate
      if (DW < 2) begin : g_bad_dw
         $error("sc_sync_seq: DW must be at least 2");
      end
      if (CNT_W < 1 || HP_W < 1 || TMR_W < 1) begin : g_bad_w
         $error("sc_sync_seq: widths must be positive");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("sc_sync_seq: SETTLE_CYC must be at least 1");
      end
   endgenerate

   seq_state_t      st_q, st_d;
   logic [SC_W-1:0] sc_q;
   logic            crst_q, expired, trig, active, run, hold_lvl;
   logic            rise_evt, fall_evt, dir_q, tx_bit;

   sc_supply_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (pwr_req),
      .load_val (pwr_tmo),
      .expired  (expired)
   );

   assign trig = rdy_gate ? sup_good : expired;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_WAIT:   if (trig) st_d = ST_SETTLE;
         ST_SETTLE: if (sc_q == SC_W'(SETTLE_CYC - 1)) st_d = ST_ACTIVE;
         default:   st_d = st_q;
      endcase
      if (pwr_req)
         st_d = ST_WAIT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         sc_q   <= '0;
         crst_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         sc_q   <= (st_q == ST_SETTLE) ? sc_q + 1'b1 : '0;
         crst_q <= rst_bit;
      end
   end

   assign active   = (st_q == ST_ACTIVE);
   assign run      = active && !clk_off;
   assign hold_lvl = active && clk_idle;

   sc_card_clock #(.HP_W(HP_W)) u_cclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .hold_lvl (hold_lvl),
      .half_bit (half_bit),
      .card_clk (card_clk),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   sc_bit_engine #(.DW(DW), .CNT_W(CNT_W)) u_bits (
      .clk        (clk),
      .rst_n      (rst_n),
      .dir_tx     (dir_tx),
      .len_reload (len_reload),
      .len_val    (len_val),
      .tx_data    (tx_data),
      .irq_clr    (irq_clr),
      .rise_evt   (rise_evt),
      .fall_evt   (fall_evt),
      .io_in      (io_in),
      .dir_q      (dir_q),
      .tx_bit     (tx_bit),
      .rx_data    (rx_data),
      .irq        (irq)
   );

   assign io_oe       = active && dir_q;
   assign io_out      = io_oe ? tx_bit : 1'b1;
   assign card_rst    = crst_q;
   assign act_done    = active;
   assign sup_expired = expired;
endmodule

// File: rtl/sc_sync_seq_chk.sv
module sc_sync_seq_chk #(
   parameter int HP_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rst_bit,
   input logic            card_rst,
   input logic            clk_off,
   input logic [HP_W-1:0] half_bit,
   input logic            card_clk,
   input logic            act_done,
   input logic            io_oe,
   input logic            io_out,
   input logic            len_reload,
   input logic            irq,
   input logic            irq_clr
);
   logic            live_q;
   logic [HP_W:0]   low_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q  <= 1'b0;
         low_run <= '0;
      end else begin
         live_q <= 1'b1;
         if (card_clk)
            low_run <= '0;
         else if (low_run != '1)
            low_run <= low_run + 1'b1;
      end
   end

   a_r4_rst_follows: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> (card_rst == $past(rst_bit)));

   a_r3_quiet_until_active: assert property (@(posedge clk) disable iff (!rst_n)
      !act_done |-> (!io_oe && io_out));

   a_r5_half_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $rose(card_clk) && !$past(clk_off)) |-> (low_run >= {1'b0, half_bit}));

   a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && irq && !irq_clr) |=> irq);

   a_r8_tx_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && io_oe && $past(io_oe) && !$past(len_reload) && !$stable(io_out))
         |-> $fell(card_clk));
endmodule

bind sc_sync_seq sc_sync_seq_chk #(.HP_W(HP_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rst_bit    (rst_bit),
   .card_rst   (card_rst),
   .clk_off    (clk_off),
   .half_bit   (half_bit),
   .card_clk   (card_clk),
   .act_done   (act_done),
   .io_oe      (io_oe),
   .io_out     (io_out),
   .len_reload (len_reload),
   .irq        (irq),
   .irq_clr    (irq_clr)
);

// File: tb/test_sc_sync_seq.sv
`timescale 1ns/1ps
module test_sc_sync_seq;
   localparam int DW = 8, CNT_W = 5, TMR_W = 8, HP_W = 4, SETTLE = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0, pwr_req = 0, rdy_gate = 0, sup_good = 0, clk_off = 1;
   logic clk_idle = 0, rst_bit = 0, dir_tx = 0, len_reload = 0, irq_clr = 0, io_in = 1;
   logic [TMR_W-1:0] pwr_tmo = '0;
   logic [HP_W-1:0]  half_bit = 4'd3;
   logic [CNT_W-1:0] len_val = '0;
   logic [DW-1:0]    tx_data = '0;
   logic card_clk, card_rst, io_out, io_oe, irq, act_done, sup_expired;
   logic [DW-1:0] rx_data;

   sc_sync_seq #(.DW(DW), .CNT_W(CNT_W), .TMR_W(TMR_W), .HP_W(HP_W), .SETTLE_CYC(SETTLE))
   i_sc_sync_seq (
      .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .pwr_tmo(pwr_tmo), .rdy_gate(rdy_gate),
      .sup_good(sup_good), .clk_off(clk_off), .clk_idle(clk_idle), .rst_bit(rst_bit),
      .dir_tx(dir_tx), .half_bit(half_bit), .len_val(len_val), .len_reload(len_reload),
      .tx_data(tx_data), .irq_clr(irq_clr), .io_in(io_in), .card_clk(card_clk),
      .card_rst(card_rst), .io_out(io_out), .io_oe(io_oe), .rx_data(rx_data), .irq(irq),
      .act_done(act_done), .sup_expired(sup_expired));

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit started = 0, done = 0;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // behavioural reference model: 0 idle, 1 wait, 2 settle, 3 active
   int m_st = 0, m_tmr = 0, m_sc = 0, m_hc = 0, m_bc = 0, m_lim = 0, m_tx = 0, m_rx = 0;
   bit m_arm = 0, m_cc = 0, m_irq = 0, m_dir = 0, m_crst = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_tmr = 0; m_sc = 0; m_hc = 0; m_bc = 0; m_lim = 0; m_tx = 0; m_rx = 0;
         m_arm = 0; m_cc = 0; m_irq = 0; m_dir = 0; m_crst = 0;
      end else begin
         automatic bit run  = (m_st == 3) && !clk_off;
         automatic bit pend = run && (m_hc == int'(half_bit) - 1);
         automatic bit rise = pend && !m_cc;
         automatic bit fall = pend && m_cc;
         automatic bit flip = (dir_tx != m_dir);
         automatic bit trig = rdy_gate ? sup_good : (m_arm && m_tmr == 0);
         automatic int nst  = m_st;
         if (m_st == 1 && trig) nst = 2;
         if (m_st == 2 && m_sc == SETTLE - 1) nst = 3;
         if (pwr_req) nst = 1;
         m_sc = (m_st == 2) ? m_sc + 1 : 0;
         if (!run) begin m_hc = 0; m_cc = (m_st == 3) && clk_idle; end
         else if (pend) begin m_hc = 0; m_cc = !m_cc; end
         else m_hc++;
         if (!len_reload && !flip && rise && m_bc != m_lim && m_bc + 1 == m_lim) m_irq = 1;
         else if (irq_clr) m_irq = 0;
         if (len_reload) begin m_bc = 0; m_lim = int'(len_val); m_tx = int'(tx_data); end
         else begin
            if (flip) m_bc = 0;
            else if (rise && m_bc != m_lim) m_bc++;
            if (fall && m_dir) m_tx = (m_tx >> 1) | 8'h80;
         end
         if (rise && !m_dir) m_rx = (m_rx >> 1) | (int'(io_in) << 7);
         m_dir = dir_tx;
         if (pwr_req) begin m_tmr = int'(pwr_tmo); m_arm = 1; end
         else if (m_tmr != 0) m_tmr--;
         m_crst = rst_bit;
         m_st = nst;
      end
      started = 1;
      cyc++;
   end

   always @(negedge clk) if (started && !done) begin
      automatic bit e_oe = (m_st == 3) && m_dir;
      check("R10/R1 act_done", act_done, m_st == 3);
      check("R2 sup_expired", sup_expired, m_arm && m_tmr == 0);
      check("R5 card_clk", card_clk, m_cc);
      check("R4 card_rst", card_rst, m_crst);
      check("R3 io_oe", io_oe, e_oe);
      check("R8 io_out", io_out, e_oe ? (m_tx & 1) : 1);
      check("R6 irq", irq, m_irq);
      check("R9 rx_data", rx_data, m_rx);
   end

   task automatic bits(input int n, input logic [7:0] pat, output logic [7:0] got);
      automatic logic prev = card_clk;
      got = '0;
      clk_off = 0;
      io_in = pat[0];
      for (int i = 0; i < n; i++) begin
         do begin prev = card_clk; @(negedge clk); end while (!(card_clk && !prev));
         got[i] = io_out;
         if (i + 1 < 8) io_in = pat[i+1];
      end
      clk_off = 1;
   endtask

   task automatic do_reset();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      automatic logic [7:0] got;
      automatic int n;
      @(negedge clk);
      do_reset();
      // R10 reset state
      check("R10 card_clk", card_clk, 0); check("R10 io_oe", io_oe, 0);
      check("R10 card_rst", card_rst, 0); check("R10 irq", irq, 0);
      check("R10 act_done", act_done, 0);

      // R1/R2/R3 timer-started activation
      pwr_tmo = 8'd6; pwr_req = 1; @(negedge clk); pwr_req = 0;
      n = 0;
      while (!act_done && n < 100) begin
         @(negedge clk); n++;
         if (n == 6) check("R2 sup_expired at tmo", sup_expired, 1);
      end
      check("R3 act_done delay after expiry", n, 6 + 1 + SETTLE);

      // R4 reset follow
      rst_bit = 1; @(negedge clk); check("R4 card_rst high", card_rst, 1);
      rst_bit = 0; @(negedge clk); check("R4 card_rst low", card_rst, 0);

      // R5 rest level
      clk_idle = 1; repeat (4) @(negedge clk); check("R5 held at idle 1", card_clk, 1);
      clk_idle = 0; repeat (2) @(negedge clk); check("R5 held at idle 0", card_clk, 0);

      // R8 / R6 transmit word
      dir_tx = 1; @(negedge clk);
      tx_data = 8'hA5; len_val = 5'd8; len_reload = 1; @(negedge clk); len_reload = 0;
      check("R3 tx drives", io_oe, 1);
      bits(8, 8'hFF, got);
      check("R8 tx word LSB first", got, 8'hA5);
      check("R6 irq at limit", irq, 1);
      repeat (10) @(negedge clk); check("R6 irq sticky", irq, 1);
      irq_clr = 1; @(negedge clk); irq_clr = 0; check("R6 irq cleared", irq, 0);

      // R7 direction flip clears count
      len_val = 5'd3; len_reload = 1; @(negedge clk); len_reload = 0;
      bits(2, 8'hFF, got);
      dir_tx = 0; @(negedge clk); @(negedge clk);
      check("R3 rx releases io", io_oe, 0);
      bits(2, 8'hFF, got);
      check("R7 no irq after flip", irq, 0);
      bits(1, 8'hFF, got);
      check("R7 irq after 3 fresh bits", irq, 1);
      irq_clr = 1; @(negedge clk); irq_clr = 0;

      // R9 receive word
      len_val = 5'd8; len_reload = 1; @(negedge clk); len_reload = 0;
      bits(8, 8'h3C, got);
      check("R9 rx word", rx_data, 8'h3C);
      check("R6 irq after rx", irq, 1);
      io_in = 1;

      // R1 ready-gated start
      do_reset();
      rdy_gate = 1; pwr_tmo = 8'd2; pwr_req = 1; @(negedge clk); pwr_req = 0;
      repeat (10) @(negedge clk);
      check("R1 timer ignored when gated", act_done, 0);
      sup_good = 1; n = 0;
      while (!act_done && n < 100) begin @(negedge clk); n++; end
      check("R1 start on supply-good", n, 1 + SETTLE);
      repeat (4) @(negedge clk);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule